// File: doc/BRIEF.md
# Block Cipher Chaining Mode Controller

This block sits between two valid/ready streams of 128-bit blocks and an iterative block cipher engine. For every block it picks one of five chaining schemes: independent blocks, cipher-block chaining, cipher feedback with a selectable segment width, output feedback, or counter. It owns the chaining register, the XOR paths and the segment shifting. The cipher engine is reached through a start pulse and a done pulse. The engine's rounds and its key storage live outside the block, so the controller only forwards a key-size code to it.

The mode, the direction and the key-size code arrive with each block and are latched together with the block data in the cycle the block is accepted, so they may change from one block to the next. Either stream can pause at any time. While a block is inside the engine, or its result is waiting for the consumer, the input side is held off. A reload strobe writes a fresh initialization value into the chaining register and so starts a new chain.

Top module: `blkmode_ctrl`

## Requirements
- R1: A whole 128-bit block is taken in the single cycle where `in_valid` and `in_ready` are both high. The engine start pulse is high for exactly the next cycle. `in_ready` stays low from acceptance until the result has been handed over, and goes high again the cycle after the output handshake.
- R2: Mode code 0 (independent blocks): the result is the engine output for the input block, and the chaining register is left unchanged.
- R3: Mode code 1 (block chaining). Encrypting: the engine receives input XOR chain, and the engine output becomes both the result and the new chain. Decrypting: the engine receives the input unchanged, the result is engine output XOR the old chain, and the input block becomes the new chain.
- R4: Mode code 2 (cipher feedback). The segment code gives the width: 0 = 8, 1 = 32, 2 = 64, 3 = 128 bits. The segment sits in the low bits of the data word, and the result sits in the low bits of the output with the upper bits zero. The engine encrypts the chain. The segment is XORed with the most significant bits of the engine output. The chain then shifts left by the segment width and takes the ciphertext segment into its low bits: the input segment when decrypting, the result segment when encrypting.
- R5: Mode code 3 (output feedback): the engine encrypts the chain, the result is input XOR engine output, and the engine output becomes the new chain.
- R6: Mode code 4 (counter): the engine encrypts the chain, the result is input XOR engine output, and the chain then increments by one modulo 2^128.
- R7: Mode codes 5 to 7 behave as code 0. The key-size code is passed to the engine unchanged for each block. Mode, direction and key size are taken per block with no extra cycles.
- R8: In modes 2, 3 and 4 the engine always runs in its encrypt direction. In modes 0 and 1 the engine direction follows `in_decrypt` (1 = decrypt).
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays unchanged and `in_ready` stays low.
- R10: `iv_load` high while the block is idle writes `iv_in` into the chaining register, which serves as both feedback and counter. Replaying the same blocks after the same reload gives the same results.
- R11: After reset, `in_ready` is 1, `out_valid` is 0, the engine start is 0 and the chaining register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iv_load | input | 1 | Reload strobe for the chaining register |
| iv_in | input | 128 | Initialization value |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Controller can take a block |
| in_data | input | 128 | Input block (segment in low bits for mode 2) |
| in_mode | input | 3 | Chaining mode code |
| in_decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| in_keysz | input | 2 | Key-size code forwarded to the engine |
| in_seg | input | 2 | Feedback segment width code |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result block |
| eng_start | output | 1 | One-cycle engine start |
| eng_decrypt | output | 1 | Engine direction, 1 = decrypt |
| eng_keysz | output | 2 | Key-size code to the engine |
| eng_din | output | 128 | Engine input block |
| eng_done | input | 1 | Engine result valid pulse |
| eng_dout | input | 128 | Engine result block |

## Verification
The assertions check the handshake rules on every cycle: a start pulse follows each acceptance and lasts one cycle, input and output are never open at the same time, a stalled result holds still, the engine direction is forced to encrypt for the feedback modes, and the key-size code is forwarded. Whether the chained values are right can only be shown by the bench scenarios. These are encrypt/decrypt round trips for block chaining, byte-wide feedback and output feedback, counter wrap at 2^128, chain reload, and a mixed-mode stream checked against a model with a latency-varying engine.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [2:0] {
    MODE_ECB = 3'd0,
    MODE_CBC = 3'd1,
    MODE_CFB = 3'd2,
    MODE_OFB = 3'd3,
    MODE_CTR = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } state_e;

  localparam int SEG_OPTS = 4;

  // Segment width for a given selector, derived from the block width.
  function automatic int seg_bits(input int blk_w, input int sel);
    case (sel)
      0:       return blk_w / 16;
      1:       return blk_w / 4;
      2:       return blk_w / 2;
      default: return blk_w;
    endcase
  endfunction

endpackage

// File: rtl/bcm_seg_unit.sv
module bcm_seg_unit
  import bcm_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] seg_sel,
  input  logic             decrypt,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] chain,
  input  logic [BLK_W-1:0] ciph,
  output logic [BLK_W-1:0] seg_res,
  output logic [BLK_W-1:0] seg_next
);

  logic [BLK_W-1:0] res_opt [SEG_OPTS];
  logic [BLK_W-1:0] nxt_opt [SEG_OPTS];

  for (genvar g = 0; g < SEG_OPTS; g++) begin : g_seg
    localparam int SW = seg_bits(BLK_W, g);
    logic [SW-1:0] keystream;
    logic [SW-1:0] plain_x;
    logic [SW-1:0] back_seg;

    assign keystream = ciph[BLK_W-1 -: SW];
    assign plain_x   = data[SW-1:0] ^ keystream;
    assign back_seg  = decrypt ? data[SW-1:0] : plain_x;
    assign res_opt[g] = BLK_W'(plain_x);

    if (SW == BLK_W) begin : g_full
      assign nxt_opt[g] = back_seg;
    end else begin : g_part
      assign nxt_opt[g] = {chain[BLK_W-SW-1:0], back_seg};
    end
  end

  always_comb begin
    seg_res  = res_opt[seg_sel];
    seg_next = nxt_opt[seg_sel];
  end

endmodule

// File: rtl/bcm_pre_xor.sv
module bcm_pre_xor
  import bcm_pkg::*;
#(
  parameter int BLK_W = 128
) (
  input  logic [2:0]       mode,
  input  logic             decrypt,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] chain,
  output logic [BLK_W-1:0] eng_in,
  output logic             eng_dec
);

  always_comb begin
    eng_in  = data;
    eng_dec = decrypt;
    case (mode)
      MODE_CBC: begin
        if (!decrypt) eng_in = data ^ chain;
      end
      MODE_CFB, MODE_OFB, MODE_CTR: begin
        eng_in  = chain;
        eng_dec = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bcm_post_xor.sv
module bcm_post_xor
  import bcm_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int SEL_W = 2
) (
  input  logic [2:0]       mode,
  input  logic             decrypt,
  input  logic [SEL_W-1:0] seg_sel,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] chain,
  input  logic [BLK_W-1:0] ciph,
  output logic [BLK_W-1:0] result,
  output logic [BLK_W-1:0] next_chain
);

  logic [BLK_W-1:0] seg_res;
  logic [BLK_W-1:0] seg_next;

  bcm_seg_unit #(.BLK_W(BLK_W), .SEL_W(SEL_W)) u_seg (
    .seg_sel (seg_sel),
    .decrypt (decrypt),
    .data    (data),
    .chain   (chain),
    .ciph    (ciph),
    .seg_res (seg_res),
    .seg_next(seg_next)
  );

  always_comb begin
    result     = ciph;
    next_chain = chain;
    case (mode)
      MODE_CBC: begin
        if (decrypt) begin
          result     = ciph ^ chain;
          next_chain = data;
        end else begin
          next_chain = ciph;
        end
      end
      MODE_CFB: begin
        result     = seg_res;
        next_chain = seg_next;
      end
      MODE_OFB: begin
        result     = data ^ ciph;
        next_chain = ciph;
      end
      MODE_CTR: begin
        result     = data ^ ciph;
        next_chain = chain + BLK_W'(1);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/blkmode_ctrl.sv
module blkmode_ctrl
  import bcm_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int KEY_W = 2,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iv_load,
  input  logic [BLK_W-1:0]  iv_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_data,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              in_decrypt,
  input  logic [KEY_W-1:0]  in_keysz,
  input  logic [1:0]        in_seg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_data,
  output logic              eng_start,
  output logic              eng_decrypt,
  output logic [KEY_W-1:0]  eng_keysz,
  output logic [BLK_W-1:0]  eng_din,
  input  logic              eng_done,
  input  logic [BLK_W-1:0]  eng_dout
);

  localparam int SEL_W = $clog2(SEG_OPTS);

  state_e            state;
  logic [BLK_W-1:0]  blk_data;
  logic [MODE_W-1:0] blk_mode;
  logic              blk_dec;
  logic [SEL_W-1:0]  blk_seg;
  logic [BLK_W-1:0]  chain_q;

  logic [BLK_W-1:0]  pre_in;
  logic              pre_dec;
  logic [BLK_W-1:0]  post_res;
  logic [BLK_W-1:0]  post_chain;

  bcm_pre_xor #(.BLK_W(BLK_W)) u_pre (
    .mode   (in_mode),
    .decrypt(in_decrypt),
    .data   (in_data),
    .chain  (chain_q),
    .eng_in (pre_in),
    .eng_dec(pre_dec)
  );

  bcm_post_xor #(.BLK_W(BLK_W), .SEL_W(SEL_W)) u_post (
    .mode      (blk_mode),
    .decrypt   (blk_dec),
    .seg_sel   (blk_seg),
    .data      (blk_data),
    .chain     (chain_q),
    .ciph      (eng_dout),
    .result    (post_res),
    .next_chain(post_chain)
  );

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      blk_data    <= '0;
      blk_mode    <= '0;
      blk_dec     <= 1'b0;
      blk_seg     <= '0;
      chain_q     <= '0;
      eng_start   <= 1'b0;
      eng_decrypt <= 1'b0;
      eng_keysz   <= '0;
      eng_din     <= '0;
      out_data    <= '0;
    end else begin
      eng_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (iv_load) chain_q <= iv_in;
          if (in_valid) begin
            blk_data    <= in_data;
            blk_mode    <= in_mode;
            blk_dec     <= in_decrypt;
            blk_seg     <= in_seg;
            eng_din     <= pre_in;
            eng_decrypt <= pre_dec;
            eng_keysz   <= in_keysz;
            eng_start   <= 1'b1;
            state       <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (eng_done) begin
            out_data <= post_res;
            chain_q  <= post_chain;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bcm_checker.sv
module bcm_checker #(
  parameter int BLK_W = 128,
  parameter int KEY_W = 2,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [MODE_W-1:0] in_mode,
  input logic [KEY_W-1:0]  in_keysz,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BLK_W-1:0]  out_data,
  input logic              eng_start,
  input logic              eng_decrypt,
  input logic [KEY_W-1:0]  eng_keysz,
  input logic              eng_done
);

  a_r1_start_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> eng_start);

  a_r1_start_single: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  a_r1_release: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> in_ready);

  a_r1_result_follows_done: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !in_ready && !out_valid) |=> out_valid);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && !in_ready));

  a_r9_sides_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  a_r8_feedback_encrypts: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_mode == 3'd2 || in_mode == 3'd3 || in_mode == 3'd4))
      |=> !eng_decrypt);

  a_r7_keysz_forward: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (eng_keysz == $past(in_keysz)));

endmodule

bind blkmode_ctrl bcm_checker #(.BLK_W(BLK_W), .KEY_W(KEY_W), .MODE_W(MODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_mode    (in_mode),
  .in_keysz   (in_keysz),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .eng_start  (eng_start),
  .eng_decrypt(eng_decrypt),
  .eng_keysz  (eng_keysz),
  .eng_done   (eng_done)
);

// File: tb/blkmode_ctrl_test.sv
`timescale 1ns/1ps
module blkmode_ctrl_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         iv_load = 1'b0;
  logic [127:0] iv_in = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [2:0]   in_mode = '0;
  logic         in_decrypt = 1'b0;
  logic [1:0]   in_keysz = '0;
  logic [1:0]   in_seg = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;
  logic         eng_start;
  logic         eng_decrypt;
  logic [1:0]   eng_keysz;
  logic [127:0] eng_din;
  logic         eng_done = 1'b0;
  logic [127:0] eng_dout = '0;

  always #2 clk = ~clk;

  blkmode_ctrl uut (
    .clk(clk), .rst(rst), .iv_load(iv_load), .iv_in(iv_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_mode(in_mode), .in_decrypt(in_decrypt), .in_keysz(in_keysz), .in_seg(in_seg),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .eng_start(eng_start), .eng_decrypt(eng_decrypt), .eng_keysz(eng_keysz),
    .eng_din(eng_din), .eng_done(eng_done), .eng_dout(eng_dout)
  );

  // Stand-in keyed permutation.
  localparam logic [127:0] ADDC = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
  function automatic logic [127:0] kmask(input logic [1:0] ks);
    return {32{ks, 2'b01}};
  endfunction
  function automatic logic [127:0] enc_f(input logic [127:0] x, input logic [1:0] ks);
    logic [127:0] y;
    y = x ^ kmask(ks);
    return {y[120:0], y[127:121]} + ADDC;
  endfunction
  function automatic logic [127:0] dec_f(input logic [127:0] x, input logic [1:0] ks);
    logic [127:0] z;
    z = x - ADDC;
    return {z[6:0], z[127:7]} ^ kmask(ks);
  endfunction

  // Engine model with a variable latency.
  int           eng_lat = 3;
  int           eb_cnt = 0;
  logic         eb_busy = 1'b0;
  logic [127:0] eb_res = '0;
  logic         seen_dec = 1'b0;
  logic [1:0]   seen_ks = '0;

  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (rst) begin
      eb_busy <= 1'b0;
    end else if (eng_start) begin
      eb_busy  <= 1'b1;
      eb_cnt   <= eng_lat;
      eb_res   <= eng_decrypt ? dec_f(eng_din, eng_keysz) : enc_f(eng_din, eng_keysz);
      seen_dec <= eng_decrypt;
      seen_ks  <= eng_keysz;
    end else if (eb_busy) begin
      if (eb_cnt <= 1) begin
        eng_done <= 1'b1;
        eng_dout <= eb_res;
        eb_busy  <= 1'b0;
      end else begin
        eb_cnt <= eb_cnt - 1;
      end
    end
  end

  int  nchk = 0;
  int  nfail = 0;
  bit  ended = 1'b0;
  logic [127:0] mchain = '0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference behaviour from the requirements.
  task automatic model(input logic [2:0] m, input logic d, input logic [1:0] ks,
                       input logic [1:0] s, input logic [127:0] x, output logic [127:0] e);
    logic [127:0] o, msk, kseg, r, c;
    int sw;
    case (m)
      3'd1: begin
        if (d) begin e = dec_f(x, ks) ^ mchain; mchain = x; end
        else   begin e = enc_f(x ^ mchain, ks); mchain = e; end
      end
      3'd2: begin
        sw   = (s == 2'd0) ? 8 : (s == 2'd1) ? 32 : (s == 2'd2) ? 64 : 128;
        msk  = (sw == 128) ? '1 : ((128'd1 << sw) - 128'd1);
        o    = enc_f(mchain, ks);
        kseg = o >> (128 - sw);
        r    = (x ^ kseg) & msk;
        c    = d ? (x & msk) : r;
        mchain = (sw == 128) ? c : ((mchain << sw) | c);
        e = r;
      end
      3'd3: begin o = enc_f(mchain, ks); e = x ^ o; mchain = o; end
      3'd4: begin o = enc_f(mchain, ks); e = x ^ o; mchain = mchain + 128'd1; end
      default: e = d ? dec_f(x, ks) : enc_f(x, ks);
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2 ecb";
      3'd1: return "R3 cbc";
      3'd2: return "R4 cfb";
      3'd3: return "R5 ofb";
      3'd4: return "R6 ctr";
      default: return "R7 unmapped";
    endcase
  endfunction

  task automatic send(input logic [2:0] m, input logic d, input logic [1:0] ks,
                      input logic [1:0] s, input logic [127:0] x);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_decrypt = d; in_keysz = ks; in_seg = s; in_data = x;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 in_ready low after accept", 128'(in_ready), 128'd0);
  endtask

  task automatic recv(input int stall, output logic [127:0] got);
    logic [127:0] first;
    out_ready = 1'b0;
    while (!out_valid) @(negedge clk);
    first = out_data;
    for (int i = 0; i < stall; i++) begin
      chk("R9 held valid/ready/data", {125'd0, out_valid, in_ready, 1'b0} ^ (out_data ^ first),
          {125'd0, 1'b1, 1'b0, 1'b0});
      @(negedge clk);
    end
    got = out_data;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic loadiv(input logic [127:0] v);
    @(negedge clk);
    iv_load = 1'b1; iv_in = v;
    @(negedge clk);
    iv_load = 1'b0;
    mchain = v;
  endtask

  typedef struct packed {
    logic [2:0]   mode;
    logic         dec;
    logic [1:0]   ks;
    logic [1:0]   seg;
    logic [127:0] data;
    logic [3:0]   lat;
    logic [3:0]   stall;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 2'd0, 2'd0, 128'h00112233445566778899aabbccddeeff, 4'd1, 4'd0},
    '{3'd0, 1'b1, 2'd2, 2'd0, 128'h3243f6a8885a308d313198a2e0370734, 4'd4, 4'd2},
    '{3'd1, 1'b0, 2'd0, 2'd0, 128'h6bc1bee22e409f96e93d7e117393172a, 4'd2, 4'd0},
    '{3'd1, 1'b0, 2'd1, 2'd0, 128'hae2d8a571e03ac9c9eb76fac45af8e51, 4'd1, 4'd3},
    '{3'd1, 1'b1, 2'd1, 2'd0, 128'h30c81c46a35ce411e5fbc1191a0a52ef, 4'd5, 4'd0},
    '{3'd2, 1'b0, 2'd0, 2'd0, 128'h000000000000000000000000000000a5, 4'd2, 4'd1},
    '{3'd2, 1'b1, 2'd0, 2'd1, 128'h000000000000000000000000deadbeef, 4'd3, 4'd0},
    '{3'd2, 1'b0, 2'd3, 2'd2, 128'h00000000000000000123456789abcdef, 4'd1, 4'd0},
    '{3'd2, 1'b1, 2'd2, 2'd3, 128'hf69f2445df4f9b17ad2b417be66c3710, 4'd2, 4'd2},
    '{3'd3, 1'b0, 2'd0, 2'd0, 128'h5555aaaa5555aaaa5555aaaa5555aaaa, 4'd3, 4'd0},
    '{3'd3, 1'b1, 2'd3, 2'd0, 128'h0123456789abcdeffedcba9876543210, 4'd1, 4'd1},
    '{3'd4, 1'b0, 2'd0, 2'd0, 128'h11111111222222223333333344444444, 4'd2, 4'd0},
    '{3'd4, 1'b1, 2'd1, 2'd0, 128'h99999999888888887777777766666666, 4'd6, 4'd0},
    '{3'd6, 1'b1, 2'd3, 2'd0, 128'hcafef00dcafef00dcafef00dcafef00d, 4'd2, 4'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [127:0] got, e, c1, c2, ca, cb, pa, pb;
    logic [127:0] ivx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 in_ready after reset", 128'(in_ready), 128'd1);
    chk("R11 out_valid after reset", 128'(out_valid), 128'd0);
    chk("R11 eng_start after reset", 128'(eng_start), 128'd0);

    // Chain starts at zero: counter block with zero data yields E(0).
    send(3'd4, 1'b0, 2'd0, 2'd0, 128'd0);
    recv(0, got);
    chk("R11 chain zero after reset", got, enc_f(128'd0, 2'd0));
    mchain = 128'd1;

    loadiv(128'h000102030405060708090a0b0c0d0e0f);
    for (int i = 0; i < NV; i++) begin
      eng_lat = int'(VEC[i].lat);
      send(VEC[i].mode, VEC[i].dec, VEC[i].ks, VEC[i].seg, VEC[i].data);
      recv(int'(VEC[i].stall), got);
      model(VEC[i].mode, VEC[i].dec, VEC[i].ks, VEC[i].seg, VEC[i].data, e);
      chk(tag_of(VEC[i].mode), got, e);
      chk("R8 engine direction", 128'(seen_dec),
          128'(VEC[i].dec && (VEC[i].mode < 3'd2 || VEC[i].mode > 3'd4)));
      chk("R7 key size forwarded", 128'(seen_ks), 128'(VEC[i].ks));
    end

    // R3 chained round trip.
    eng_lat = 2;
    ivx = 128'hfeedfacecafebeef0011223344556677;
    pa = 128'h1111222233334444555566667777aaaa;
    pb = 128'h9999888877776666555544443333bbbb;
    loadiv(ivx);
    send(3'd1, 1'b0, 2'd3, 2'd0, pa); recv(0, c1);
    send(3'd1, 1'b0, 2'd3, 2'd0, pb); recv(0, c2);
    loadiv(ivx);
    send(3'd1, 1'b1, 2'd3, 2'd0, c1); recv(1, got);
    chk("R3 round trip block 1", got, pa);
    send(3'd1, 1'b1, 2'd3, 2'd0, c2); recv(0, got);
    chk("R3 round trip block 2", got, pb);

    // R4 byte-segment round trip.
    loadiv(ivx);
    send(3'd2, 1'b0, 2'd1, 2'd0, 128'h3c); recv(0, ca);
    send(3'd2, 1'b0, 2'd1, 2'd0, 128'hc3); recv(0, cb);
    chk("R4 upper bits zero", ca >> 8, 128'd0);
    loadiv(ivx);
    send(3'd2, 1'b1, 2'd1, 2'd0, ca); recv(0, got);
    chk("R4 round trip seg 1", got, 128'h3c);
    send(3'd2, 1'b1, 2'd1, 2'd0, cb); recv(0, got);
    chk("R4 round trip seg 2", got, 128'hc3);

    // R5 output feedback round trip.
    loadiv(ivx);
    send(3'd3, 1'b0, 2'd0, 2'd0, pa); recv(0, ca);
    send(3'd3, 1'b0, 2'd0, 2'd0, pb); recv(0, cb);
    loadiv(ivx);
    send(3'd3, 1'b1, 2'd0, 2'd0, ca); recv(0, got);
    chk("R5 round trip block 1", got, pa);
    send(3'd3, 1'b1, 2'd0, 2'd0, cb); recv(0, got);
    chk("R5 round trip block 2", got, pb);

    // R6 counter wrap.
    loadiv('1);
    send(3'd4, 1'b0, 2'd2, 2'd0, 128'd0); recv(0, got);
    chk("R6 counter at max", got, enc_f('1, 2'd2));
    send(3'd4, 1'b0, 2'd2, 2'd0, 128'd0); recv(0, got);
    chk("R6 counter wrapped to zero", got, enc_f(128'd0, 2'd2));

    // R10 reload restarts the chain.
    loadiv(128'h42);
    send(3'd4, 1'b0, 2'd0, 2'd0, pa); recv(0, ca);
    loadiv(128'h42);
    send(3'd4, 1'b0, 2'd0, 2'd0, pa); recv(4, cb);
    chk("R10 same result after reload", cb, ca);
    chk("R10 counter value used", ca, pa ^ enc_f(128'h42, 2'd0));

    ended = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule